// File: doc/BRIEF.md
# Interleaved Frequency-Modulated Multiphase PWM

This block drives the switching signals of N parallel power-stage channels. The switching period changes from one cycle to the next, so that the energy of the switching harmonics spreads into side bands. At the same time the channels stay evenly interleaved: in every switching cycle, channel i places its pulse a fraction i/N of that cycle's own period after the reference channel. The period sequence is supplied as a table of L reference periods in clock counts, covering one period of the modulation profile, and the block replays it without end.

Interleaving is kept in two ways. At start-up, each channel is held back by its share of the first table period. After that, each non-reference channel runs a corrected period for every cycle, recomputed from the current and next table entries, so that its offset follows the instantaneous period. One duty-compare value is shared by all channels.

A deasserted enable stops every channel and clears it. The next enable restarts the whole staggered sequence from table entry 0.

Top module: `mfpwm_interleave`

## Requirements
- R1: While reset is asserted, every PWM output is low, whatever the enable input is.
- R2: While enable is low, every PWM output is low. From the clock edge after enable falls, all outputs stay low.
- R3: Channel 0 is the reference channel. Its counter starts at 0 in the cycle after the first clock edge that sees enable high. It then runs periods T[0], T[1], ..., T[L-1], T[0], ... where T[k] is bits [k*W +: W] of the table input.
- R4: Channel i (i = 0..N-1) starts floor(T[0]*i/N) cycles after channel 0. Its pulse begins in that cycle.
- R5: Let S_k be the sum of the first k reference periods, with the table index taken modulo L. Channel i begins its k-th pulse exactly S_k + floor(T[k mod L]*i/N) cycles after channel 0 started. This holds across the wrap from entry L-1 back to entry 0.
- R6: A pulse stays high for min(duty, current channel period) cycles from its start. A duty value of 0 keeps all outputs low. A duty value no smaller than every period keeps a running channel high all the time.
- R7: Dropping enable in the middle of a run stops all channels. The next rising enable restarts the stagger and the table from entry 0, exactly as after reset.

Table entries are assumed to lie between 8 and 2^W-8 and to stay constant while enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable for all channels |
| duty | input | W | Shared compare value: on-time in clock cycles |
| period_tbl | input | L*W | Packed table of reference periods, entry k at bits [k*W +: W] |
| pwm | output | N | PWM outputs, bit i drives channel i |

## Verification
A faulty correction term moves a non-reference channel's rising edge by one or more cycles at the next boundary of that channel's period. Such an error then persists as a shifted phase in every later cycle. A stagger fault shows within the first table period, before channel N-1 has switched once. An index wrap fault appears only after L switching cycles. For this reason the bench compares every output in every cycle over more than one full table pass, against absolute edge times computed from the running sum of table periods. Runs with duty at zero and at its maximum, together with a disable in the middle of a run, expose stuck or stale state at the outputs within one cycle.

// File: rtl/mfpwm_pkg.sv
package mfpwm_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/mfpwm_stagger.sv
module mfpwm_stagger #(
    parameter int N = 4,
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] t0_i,
    output logic [N-1:0] start_o
);
    localparam int SH = (N > 1) ? $clog2(N) : 0;
    localparam int PW = W + SH;

    typedef struct packed {
        logic [W-1:0] el;
        logic         done;
    } stg_t;

    stg_t q, d;
    logic [W-1:0] dly [N];

    for (genvar j = 0; j < N; j++) begin : g_dly
        logic [PW-1:0] prod;
        assign prod = PW'(t0_i) * PW'(j);
        assign dly[j] = W'(prod >> SH);
        assign start_o[j] = en_i & ~q.done & (q.el == dly[j]);
    end

    always_comb begin
        d = q;
        if (!en_i) begin
            d.el   = '0;
            d.done = 1'b0;
        end else if (!q.done) begin
            if (q.el == dly[N-1]) begin
                d.done = 1'b1;
            end else begin
                d.el = q.el + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.el   <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R4: elapsed counter never runs past the last channel's delay
    p_el_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.done) |-> (q.el <= dly[N-1]));

    // R7: a low enable re-arms the stagger
    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (q.el == '0 && !q.done));

endmodule

// File: rtl/mfpwm_channel.sv
module mfpwm_channel
    import mfpwm_pkg::*;
#(
    parameter int N     = 4,
    parameter int L     = 40,
    parameter int W     = 10,
    parameter int PHASE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           start_i,
    input  logic [L*W-1:0] tbl_i,
    input  logic [W-1:0]   duty_i,
    output logic           pwm_o
);
    localparam int SH = (N > 1) ? $clog2(N) : 0;
    localparam int PW = W + SH;
    localparam int IW = (L > 1) ? $clog2(L) : 1;

    typedef struct packed {
        ch_state_e    st;
        logic [W-1:0] cnt;
        logic [IW-1:0] idx;
        logic [W-1:0] per;
        logic [W-1:0] nxt;
    } ch_t;

    ch_t q, d;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] k);
        return (k == IW'(L - 1)) ? '0 : k + 1'b1;
    endfunction

    // corrected period: T[k] + off(T[k+1]) - off(T[k]), off(T) = floor(T*PHASE/N)
    function automatic logic [W-1:0] calc(input logic [IW-1:0] k);
        logic [W-1:0]  ta;
        logic [W-1:0]  tb;
        logic [PW-1:0] ma;
        logic [PW-1:0] mb;
        ta = tbl_i[k*W +: W];
        tb = tbl_i[wrap_inc(k)*W +: W];
        ma = PW'(ta) * PW'(PHASE);
        mb = PW'(tb) * PW'(PHASE);
        return ta + W'(mb >> SH) - W'(ma >> SH);
    endfunction

    logic [IW-1:0] idx_inc;
    assign idx_inc = wrap_inc(q.idx);

    always_comb begin
        d = q;
        d.nxt = calc(idx_inc);
        if (!en_i) begin
            d.st  = CH_IDLE;
            d.cnt = '0;
            d.idx = '0;
        end else if (q.st == CH_IDLE) begin
            if (start_i) begin
                d.st  = CH_RUN;
                d.cnt = '0;
                d.idx = '0;
                d.per = calc('0);
            end
        end else if (q.cnt == q.per - 1'b1) begin
            d.cnt = '0;
            d.idx = idx_inc;
            d.per = q.nxt;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= CH_IDLE;
            q.cnt <= '0;
            q.idx <= '0;
            q.per <= '0;
            q.nxt <= '0;
        end else begin
            q <= d;
        end
    end

    assign pwm_o = (q.st == CH_RUN) && (q.cnt < duty_i);

    // R3: counter stays inside the latched period
    p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CH_RUN) |-> (q.cnt < q.per));

    // R3: table index stays inside the table
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IW'(L - 1));

    // R5: a full period always rolls the counter back to zero
    p_rollover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CH_RUN && q.cnt == q.per - 1'b1) |=> (q.cnt == '0));

    // R6: zero duty never drives the output
    p_duty0_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |-> !pwm_o);

endmodule

// File: rtl/mfpwm_interleave.sv
module mfpwm_interleave #(
    parameter int N = 4,
    parameter int L = 40,
    parameter int W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [W-1:0]   duty,
    input  logic [L*W-1:0] period_tbl,
    output logic [N-1:0]   pwm
);
    logic [N-1:0] start;

    mfpwm_stagger #(.N(N), .W(W)) u_stagger (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .t0_i    (period_tbl[W-1:0]),
        .start_o (start)
    );

    for (genvar i = 0; i < N; i++) begin : g_ch
        mfpwm_channel #(.N(N), .L(L), .W(W), .PHASE(i)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en),
            .start_i (start[i]),
            .tbl_i   (period_tbl),
            .duty_i  (duty),
            .pwm_o   (pwm[i])
        );
    end

    // R2: outputs go low the edge after enable is seen low
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (pwm == '0));

endmodule

// File: tb/tb_mfpwm_interleave.sv
module tb_mfpwm_interleave;
    localparam int CLK_NS = 10;
    localparam int N = 4;
    localparam int L = 40;
    localparam int W = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b0;
    logic [W-1:0]   duty = '0;
    logic [L*W-1:0] tbl = '0;
    logic [N-1:0]   pwm;

    int tv [L];
    int nvec = 0;
    int nbad = 0;

    mfpwm_interleave #(.N(N), .L(L), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .duty(duty),
        .period_tbl(tbl), .pwm(pwm)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req, input int t, input int ch);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s t=%0d ch=%0d actual=%b expected=%b", req, t, ch, act, exp);
        end
    endtask

    function automatic int ofs(input int tper, input int i);
        return (tper * i) / N;
    endfunction

    task automatic load_table(input int kind);
        for (int k = 0; k < L; k++) begin
            if (kind == 0) begin
                // triangular sweep 360..440 kHz at 100 MHz
                int f;
                f = (k <= L/2) ? 360 + 4*k : 440 - 4*(k - L/2);
                tv[k] = 100000 / f;
            end else begin
                tv[k] = 20 + ((k * 37) % 29);
            end
            tbl[k*W +: W] = W'(tv[k]);
        end
    endtask

    // R3/R4/R5/R6: run from a fresh enable, compare every output each cycle
    task automatic run_phase(input int ncyc);
        int kc [N];
        int sk [N];
        for (int i = 0; i < N; i++) begin
            kc[i] = 0;
            sk[i] = 0;
        end
        @(negedge clk) en = 1'b1;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                int nr;
                int cr;
                logic exp;
                string req;
                nr = sk[i] + tv[kc[i] % L] + ofs(tv[(kc[i] + 1) % L], i);
                if (t == nr) begin
                    sk[i] += tv[kc[i] % L];
                    kc[i]++;
                end
                cr = sk[i] + ofs(tv[kc[i] % L], i);
                exp = (t >= cr) && (t - cr < int'(duty));
                if (duty == '0 || duty == '1) req = "R6";
                else if (kc[i] == 0)          req = "R4";
                else if (i == 0)              req = "R3";
                else                          req = "R5";
                check(pwm[i], exp, req, t, i);
            end
        end
    endtask

    // R2/R7: disable, outputs must drop and stay low
    task automatic stop_and_check(input int idle);
        @(negedge clk) en = 1'b0;
        for (int t = 0; t < idle; t++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) check(pwm[i], 1'b0, (t == 0) ? "R7" : "R2", t, i);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        load_table(0);
        duty = W'(60);
        en = 1'b1;
        // R1: outputs low under reset even with enable high
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) check(pwm[i], 1'b0, "R1", t, i);
        end
        en = 1'b0;
        rst_n = 1'b1;
        stop_and_check(5);

        run_phase(20500);          // over two table passes, wrap included
        stop_and_check(4);

        duty = '0;
        run_phase(2000);
        stop_and_check(3);

        duty = '1;
        run_phase(2000);
        stop_and_check(3);

        load_table(1);
        duty = W'(7);
        run_phase(3000);
        stop_and_check(3);

        duty = W'(1);
        run_phase(537);            // cut short mid-sequence
        stop_and_check(6);
        run_phase(1500);           // restart from entry 0
        stop_and_check(3);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule